// File: doc/BRIEF.md
# Serial Configuration Slave with Fault Snapshot

This block is the host-facing serial port of a peak-and-hold solenoid predriver. The host sends 16-bit frames on a four-wire SPI link (mode 0: clock idle low, data sampled on the rising clock edge). The high byte of each frame is a select byte and the low byte is the value to store. At the same time, the slave shifts back a word whose low five bits are a snapshot of the fault status.

The select byte is decoded one bit per register. One frame can therefore load the same byte into any mix of the six configuration registers: mode, hold-low, hold-high, peak-low, peak-high and dwell. A frame with an all-zero select byte is a pure status read. A frame is dropped unless it carried exactly sixteen clock pulses and its two top select bits are zero.

The SPI pins are oversampled by the system clock through a synchronizer. A register update lands together with a one-cycle `frame_done` pulse that downstream fault-clear logic can use.

Top module: `spi_cfg_slave`

## Requirements
- R1: While reset is asserted and after its release, all six configuration outputs read 0x00, `spi_sdo_oe` is low and `frame_done` is low.
- R2: A frame is sent MSB first, with SDI sampled on rising SCLK. Frame bits 15..8 form the select byte and bits 7..0 form the data byte. Select bit 0 writes `cfg_mode`, bit 1 `cfg_hold_lo`, bit 2 `cfg_hold_hi`, bit 3 `cfg_peak_lo`, bit 4 `cfg_peak_hi` and bit 5 `cfg_dwell`.
- R3: When several of select bits 5..0 are set, every selected register receives the same data byte in the same cycle.
- R4: A frame with select byte 0x00 changes no register.
- R5: A frame whose rising-SCLK count between CSN falling and CSN rising is not exactly 16 (including zero) changes no register.
- R6: A frame with select bit 7 or bit 6 set changes no register.
- R7: On CSN falling, the held fault snapshot is loaded into the transmit word at bits 4..0, with bits 15..5 zero. The word goes out MSB first, and SDO advances on each falling SCLK, so each bit is valid before the next rising edge.
- R8: `fault_capture` stores `fault_in` into the snapshot only while no frame is active. A strobe during a frame neither alters the word being shifted out nor is kept for a later frame.
- R9: `spi_sdo_oe` is low while CSN is high (SDO to be treated as high-impedance) and high while a frame is active.
- R10: Every CSN rising edge produces a `frame_done` pulse exactly one clock long. Register contents change only in a cycle where `frame_done` is high.
- R11: The fault snapshot is cleared at CSN rising. A following frame with no new capture returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_csn | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_oe | output | 1 | Drive enable for SDO; pad is high-impedance when low |
| fault_in | input | 5 | Fault status from the detection logic |
| fault_capture | input | 1 | Strobe that stores `fault_in` into the snapshot |
| frame_done | output | 1 | One-cycle pulse after each chip-select release |
| cfg_mode | output | 8 | Mode and threshold option register |
| cfg_hold_lo | output | 8 | Hold-phase lower current reference |
| cfg_hold_hi | output | 8 | Hold-phase upper current reference |
| cfg_peak_lo | output | 8 | Peak-phase lower current reference |
| cfg_peak_hi | output | 8 | Peak-phase upper current reference |
| cfg_dwell | output | 8 | Peak dwell count |

## Verification
The bench uses the default parameters: 16-bit frames, 8-bit data, six registers, five fault bits and a two-stage synchronizer. With these values, all six select bits and both reserved select bits can be reached from ordinary frames. So can both counter boundaries: a 15-pulse frame and a 17-pulse frame, where the counter saturates. The serial half-period is six system clocks, so every synchronized edge is settled before the next one. This lets the bench sample SDO just before each rising SCLK and land on the exact bit the snapshot placed there.

// File: rtl/spi_cfg_pkg.sv
`timescale 1ns/1ps
package spi_cfg_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned NUM_REGS   = 6;
  localparam int unsigned FLT_BITS   = 5;

  // Register slot = position of its select bit in the select byte.
  typedef enum int unsigned {
    SEL_MODE    = 0,
    SEL_HOLD_LO = 1,
    SEL_HOLD_HI = 2,
    SEL_PEAK_LO = 3,
    SEL_PEAK_HI = 4,
    SEL_DWELL   = 5
  } reg_sel_e;
endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the serial pins; edge detect on the pins that need it.
module spi_in_sync #(
  parameter int unsigned EW = 2,
  parameter int unsigned PW = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [EW-1:0] EDGE_RST = '0,
  parameter logic [PW-1:0] PLAIN_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] edge_in,
  input  logic [PW-1:0] plain_in,
  output logic [EW-1:0] edge_rise,
  output logic [EW-1:0] edge_fall,
  output logic [PW-1:0] plain_lvl
);
  localparam int unsigned W = EW + PW;
  localparam logic [W-1:0] RST_VAL = {EDGE_RST, PLAIN_RST};

  logic [STAGES-1:0][W-1:0] chain_q, chain_d;
  logic [W-1:0]  synced;
  logic [EW-1:0] prev_q, prev_d;

  always_comb begin
    chain_d[0] = {edge_in, plain_in};
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  assign synced = chain_q[STAGES-1];
  assign prev_d = synced[W-1 -: EW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= EDGE_RST;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign edge_rise = synced[W-1 -: EW] & ~prev_q;
  assign edge_fall = ~synced[W-1 -: EW] & prev_q;
  assign plain_lvl = synced[PW-1:0];
endmodule

// File: rtl/spi_frame_rx.sv
`timescale 1ns/1ps
// Receive shifter and saturating pulse counter for one chip-select window.
module spi_frame_rx #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               cs_active,
  input  logic               sclk_rise,
  input  logic               sdi,
  output logic [FRAME_W-1:0] rx_word,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               shift_en;

  assign shift_en = sclk_rise & cs_active;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (frame_start) begin
      cnt_d = '0;
    end else if (shift_en) begin
      word_d = {word_q[FRAME_W-2:0], sdi};
      if (cnt_q != CNT_SAT) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rx_word = word_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/spi_fault_tx.sv
`timescale 1ns/1ps
// Fault snapshot holder and transmit shifter.
module spi_fault_tx #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned FLT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_fall,
  input  logic [FLT_W-1:0] fault_in,
  input  logic             fault_capture,
  output logic             sdo
);
  localparam int unsigned PAD_W = FRAME_W - FLT_W;

  logic [FLT_W-1:0]   hold_q, hold_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic               hold_clr, hold_en, tx_load, tx_shift;

  assign hold_clr = cs_rise;
  assign hold_en  = fault_capture & ~cs_active;
  assign tx_load  = cs_fall;
  assign tx_shift = sclk_fall & cs_active;

  always_comb begin
    hold_d = hold_q;
    if (hold_clr) begin
      hold_d = '0;
    end else if (hold_en) begin
      hold_d = fault_in;
    end
  end

  always_comb begin
    tx_d = tx_q;
    if (tx_load) begin
      tx_d = {{PAD_W{1'b0}}, hold_q};
    end else if (tx_shift) begin
      tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      tx_q   <= '0;
    end else begin
      hold_q <= hold_d;
      tx_q   <= tx_d;
    end
  end

  assign sdo = tx_q[FRAME_W-1];
endmodule

// File: rtl/spi_reg_bank.sv
`timescale 1ns/1ps
// Configuration registers with one write enable per select bit.
module spi_reg_bank #(
  parameter int unsigned NREG = 6,
  parameter int unsigned DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [NREG-1:0]          sel,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  reg_bus
);
  logic [NREG-1:0]         reg_we;
  logic [NREG-1:0][DW-1:0] reg_q, reg_d;

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign reg_we[g] = wr_en & sel[g];
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      reg_d[i] = reg_we[i] ? wdata : reg_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else begin
      reg_q <= reg_d;
    end
  end

  assign reg_bus = reg_q;
endmodule

// File: rtl/spi_cfg_slave.sv
`timescale 1ns/1ps
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int unsigned FRAME_W = FRAME_BITS,
  parameter int unsigned DW = DATA_BITS,
  parameter int unsigned FLT_W = FLT_BITS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_csn,
  input  logic             spi_sclk,
  input  logic             spi_sdi,
  output logic             spi_sdo,
  output logic             spi_sdo_oe,
  input  logic [FLT_W-1:0] fault_in,
  input  logic             fault_capture,
  output logic             frame_done,
  output logic [DW-1:0]    cfg_mode,
  output logic [DW-1:0]    cfg_hold_lo,
  output logic [DW-1:0]    cfg_hold_hi,
  output logic [DW-1:0]    cfg_peak_lo,
  output logic [DW-1:0]    cfg_peak_hi,
  output logic [DW-1:0]    cfg_dwell
);
  localparam int unsigned NREG   = NUM_REGS;
  localparam int unsigned ADDR_W = FRAME_W - DW;
  localparam int unsigned TEST_W = ADDR_W - NREG;
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 2);

  // Reset: asserted asynchronously, released through a short chain.
  logic [SYNC_STAGES-1:0] rst_chain_q, rst_chain_d;
  logic rst_n_int;

  assign rst_chain_d = (rst_chain_q << 1) | SYNC_STAGES'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_chain_q <= '0;
    end else begin
      rst_chain_q <= rst_chain_d;
    end
  end

  assign rst_n_int = rst_chain_q[SYNC_STAGES-1];

  // Pin synchronizer: {csn, sclk} edge detected, sdi level only.
  logic [1:0] pin_rise, pin_fall;
  logic       sdi_s;
  logic       cs_rise, cs_fall, sclk_rise, sclk_fall;

  spi_in_sync #(
    .EW(2), .PW(1), .STAGES(SYNC_STAGES),
    .EDGE_RST(2'b10), .PLAIN_RST(1'b0)
  ) u_sync (
    .clk(clk), .rst_n(rst_n_int),
    .edge_in({spi_csn, spi_sclk}), .plain_in(spi_sdi),
    .edge_rise(pin_rise), .edge_fall(pin_fall), .plain_lvl(sdi_s)
  );

  assign cs_rise   = pin_rise[1];
  assign cs_fall   = pin_fall[1];
  assign sclk_rise = pin_rise[0];
  assign sclk_fall = pin_fall[0];

  // Frame-active state.
  logic cs_active_q, cs_active_d;

  always_comb begin
    cs_active_d = cs_active_q;
    if (cs_fall) begin
      cs_active_d = 1'b1;
    end else if (cs_rise) begin
      cs_active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cs_active_q <= 1'b0;
    end else begin
      cs_active_q <= cs_active_d;
    end
  end

  // Receive path.
  logic [FRAME_W-1:0] rx_word;
  logic [CNT_W-1:0]   bit_cnt;

  spi_frame_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n_int),
    .frame_start(cs_fall), .cs_active(cs_active_q),
    .sclk_rise(sclk_rise), .sdi(sdi_s),
    .rx_word(rx_word), .bit_cnt(bit_cnt)
  );

  // Transmit path.
  spi_fault_tx #(.FRAME_W(FRAME_W), .FLT_W(FLT_W)) u_tx (
    .clk(clk), .rst_n(rst_n_int),
    .cs_active(cs_active_q), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .fault_in(fault_in),
    .fault_capture(fault_capture), .sdo(spi_sdo)
  );

  assign spi_sdo_oe = cs_active_q;

  // Command decode.
  logic [ADDR_W-1:0] sel_byte;
  logic [TEST_W-1:0] test_bits;
  logic [DW-1:0]     wdata;
  logic              full_frame, accept;

  assign sel_byte   = rx_word[FRAME_W-1 -: ADDR_W];
  assign test_bits  = sel_byte[ADDR_W-1 -: TEST_W];
  assign wdata      = rx_word[DW-1:0];
  assign full_frame = (bit_cnt == CNT_W'(FRAME_W));
  assign accept     = cs_rise & full_frame & ~(|test_bits);

  logic [NREG-1:0][DW-1:0] reg_bus;

  spi_reg_bank #(.NREG(NREG), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .wr_en(accept), .sel(sel_byte[NREG-1:0]), .wdata(wdata),
    .reg_bus(reg_bus)
  );

  // Frame-done pulse, aligned with the register update.
  logic done_q, done_d;

  assign done_d = cs_rise;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign frame_done  = done_q;
  assign cfg_mode    = reg_bus[SEL_MODE];
  assign cfg_hold_lo = reg_bus[SEL_HOLD_LO];
  assign cfg_hold_hi = reg_bus[SEL_HOLD_HI];
  assign cfg_peak_lo = reg_bus[SEL_PEAK_LO];
  assign cfg_peak_hi = reg_bus[SEL_PEAK_HI];
  assign cfg_dwell   = reg_bus[SEL_DWELL];
endmodule

// File: rtl/spi_cfg_slave_chk.sv
`timescale 1ns/1ps
module spi_cfg_slave_chk #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned NREG = 6,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned TEST_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frame_done,
  input logic                    sdo,
  input logic                    sdo_oe,
  input logic [NREG-1:0][DW-1:0] reg_bus,
  input logic [FRAME_W-1:0]      rx_word,
  input logic [CNT_W-1:0]        bit_cnt
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_state_chk: assert (reg_bus == '0 && !frame_done && !sdo_oe);
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(reg_bus));

  // R6
  test_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && (|rx_word[FRAME_W-1 -: TEST_W])) |-> $stable(reg_bus));

  // R5
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && (bit_cnt != CNT_W'(FRAME_W))) |-> $stable(reg_bus));

  // R9
  idle_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe && $past(!sdo_oe)) |-> $stable(sdo));
endmodule

bind spi_cfg_slave spi_cfg_slave_chk #(
  .FRAME_W(FRAME_W), .DW(DW), .NREG(NREG), .CNT_W(CNT_W), .TEST_W(TEST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
  .sdo(spi_sdo), .sdo_oe(spi_sdo_oe), .reg_bus(reg_bus),
  .rx_word(rx_word), .bit_cnt(bit_cnt)
);

// File: tb/tb_spi_cfg_slave.sv
`timescale 1ns/1ps
module tb_spi_cfg_slave;
  localparam int HALF = 6;
  localparam int NVEC = 14;
  localparam int WD_CYCLES = 150000;

  logic clk, rst_n, spi_csn, spi_sclk, spi_sdi, fault_capture;
  logic [4:0] fault_in;
  logic spi_sdo, spi_sdo_oe, frame_done;
  logic [7:0] cfg_mode, cfg_hold_lo, cfg_hold_hi, cfg_peak_lo, cfg_peak_hi, cfg_dwell;

  spi_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .fault_in(fault_in), .fault_capture(fault_capture), .frame_done(frame_done),
    .cfg_mode(cfg_mode), .cfg_hold_lo(cfg_hold_lo), .cfg_hold_hi(cfg_hold_hi),
    .cfg_peak_lo(cfg_peak_lo), .cfg_peak_hi(cfg_peak_hi), .cfg_dwell(cfg_dwell)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // frame_done monitor: rising edges and high cycles
  int fd_pulses = 0;
  int fd_high = 0;
  logic fd_prev = 1'b0;
  always @(posedge clk) begin
    if (frame_done === 1'b1) fd_high++;
    if (frame_done === 1'b1 && fd_prev !== 1'b1) fd_pulses++;
    fd_prev = frame_done;
  end

  // {cmd[15:0], nbits[4:0], fault[4:0], expected {mode,hlo,hhi,plo,phi,dwell}}
  localparam logic [73:0] VECS [NVEC] = '{
    {16'h01A5, 5'd16, 5'h01, 48'hA5_00_00_00_00_00},
    {16'h0233, 5'd16, 5'h02, 48'hA5_33_00_00_00_00},
    {16'h0444, 5'd16, 5'h04, 48'hA5_33_44_00_00_00},
    {16'h0855, 5'd16, 5'h08, 48'hA5_33_44_55_00_00},
    {16'h1066, 5'd16, 5'h10, 48'hA5_33_44_55_66_00},
    {16'h2077, 5'd16, 5'h1F, 48'hA5_33_44_55_66_77},
    {16'h0A5C, 5'd16, 5'h15, 48'hA5_5C_44_5C_66_77},
    {16'h3F11, 5'd16, 5'h0A, 48'h11_11_11_11_11_11},
    {16'h00FF, 5'd16, 5'h00, 48'h11_11_11_11_11_11},
    {16'h41EE, 5'd16, 5'h03, 48'h11_11_11_11_11_11},
    {16'h81EE, 5'd16, 5'h1C, 48'h11_11_11_11_11_11},
    {16'h0122, 5'd15, 5'h07, 48'h11_11_11_11_11_11},
    {16'h0122, 5'd17, 5'h18, 48'h11_11_11_11_11_11},
    {16'h209A, 5'd16, 5'h11, 48'h11_11_11_11_11_9A}
  };

  function automatic string row_tag(int i);
    if (i <= 5 || i == 13) return "R2";
    if (i <= 7) return "R3";
    if (i == 8) return "R4";
    if (i <= 10) return "R6";
    return "R5";
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [47:0] reg_view();
    return {cfg_mode, cfg_hold_lo, cfg_hold_hi, cfg_peak_lo, cfg_peak_hi, cfg_dwell};
  endfunction

  task automatic capture(logic [4:0] f);
    fault_in = f;
    fault_capture = 1'b1;
    tick(1);
    fault_capture = 1'b0;
    tick(1);
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input bit midcap,
                       output logic [15:0] got, output bit oe_ok);
    got = '0;
    oe_ok = 1;
    spi_csn = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = (i < 16) ? w[15-i] : 1'b0;
      if (midcap && i == 4) begin
        fault_in = 5'h1C;
        fault_capture = 1'b1;
        tick(1);
        fault_capture = 1'b0;
      end
      tick(HALF);
      if (i < 16) got[15-i] = spi_sdo;
      if (spi_sdo_oe !== 1'b1) oe_ok = 0;
      spi_sclk = 1'b1;
      tick(HALF);
      spi_sclk = 1'b0;
    end
    tick(HALF);
    spi_csn = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
  endtask

  initial begin
    logic [15:0] got;
    bit oe_ok;
    int p0, h0;
    rst_n = 1'b0;
    spi_csn = 1'b1;
    spi_sclk = 1'b0;
    spi_sdi = 1'b0;
    fault_in = '0;
    fault_capture = 1'b0;
    tick(3);
    // R1: state during reset
    check("R1", "regs in reset", {16'h0, reg_view()}, 64'h0);
    check("R1", "sdo_oe in reset", {63'h0, spi_sdo_oe}, 64'h0);
    rst_n = 1'b1;
    tick(4);
    check("R1", "regs after reset", {16'h0, reg_view()}, 64'h0);
    check("R1", "frame_done after reset", {63'h0, frame_done}, 64'h0);
    // R9: idle enable
    check("R9", "sdo_oe idle", {63'h0, spi_sdo_oe}, 64'h0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] cmd;
      int nb;
      logic [4:0] flt;
      logic [47:0] exp;
      cmd = VECS[i][73:58];
      nb  = int'(VECS[i][57:53]);
      flt = VECS[i][52:48];
      exp = VECS[i][47:0];
      capture(flt);
      p0 = fd_pulses;
      h0 = fd_high;
      frame(cmd, nb, 0, got, oe_ok);
      check(row_tag(i), $sformatf("regs row %0d", i), {16'h0, reg_view()}, {16'h0, exp});
      if (nb == 16) begin
        // R7: returned word
        check("R7", $sformatf("fault word row %0d", i), {48'h0, got}, {48'h0, 11'h0, flt});
      end
      // R10: one pulse, one cycle
      check("R10", $sformatf("done pulses row %0d", i), 64'(fd_pulses - p0), 64'd1);
      check("R10", $sformatf("done width row %0d", i), 64'(fd_high - h0), 64'd1);
      // R9
      check("R9", $sformatf("sdo_oe active row %0d", i), {63'h0, oe_ok}, 64'h1);
      check("R9", $sformatf("sdo_oe released row %0d", i), {63'h0, spi_sdo_oe}, 64'h0);
    end

    // R11: snapshot cleared at frame end
    capture(5'h1F);
    frame(16'h0000, 16, 0, got, oe_ok);
    check("R11", "captured word", {48'h0, got}, 64'h001F);
    frame(16'h0000, 16, 0, got, oe_ok);
    check("R11", "word after clear", {48'h0, got}, 64'h0000);

    // R8: strobe during frame ignored
    capture(5'h03);
    frame(16'h0000, 16, 1, got, oe_ok);
    check("R8", "word with mid-frame strobe", {48'h0, got}, 64'h0003);
    frame(16'h0000, 16, 0, got, oe_ok);
    check("R8", "mid-frame strobe not kept", {48'h0, got}, 64'h0000);

    // R5: chip-select toggle with no clocks
    p0 = fd_pulses;
    frame(16'h01FF, 0, 0, got, oe_ok);
    check("R5", "zero-clock frame", {16'h0, reg_view()}, 64'h0000_1111_1111_119A);
    check("R10", "done on empty frame", 64'(fd_pulses - p0), 64'd1);

    // R2: broadcast then a single write on top
    frame(16'h3F00, 16, 0, got, oe_ok);
    frame(16'h1042, 16, 0, got, oe_ok);
    check("R2", "peak_hi only", {16'h0, reg_view()}, 64'h0000_0000_0000_4200);

    // R1: reset mid-run
    frame(16'h3FC3, 16, 0, got, oe_ok);
    check("R3", "all six loaded", {16'h0, reg_view()}, 64'h0000_C3C3_C3C3_C3C3);
    do_reset();
    check("R1", "regs after mid-run reset", {16'h0, reg_view()}, 64'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule